// File: doc/BRIEF.md
# Dual DAC Byte Loader with Simultaneous Transfer

This block sits between a byte-addressed register bus and two digital-to-analog converter channels. Each channel has a 16-bit holding register that software loads as two bytes, low byte first and then high byte, or as one 16-bit word. A second register stage, the output register, drives the converter. A shared range register holds a 2-bit range code for each channel. The converters themselves are outside the block.

A mode input, normally tied to a board strap, chooses when the output registers take the holding values. In individual mode, writing the high byte of a channel commits that channel on the same clock edge. In transfer mode, writes only fill the holding registers. Any read of a converter address then commits both channels on the same edge, so the two outputs change together.

The `DATA_W` parameter selects a 16-bit or a 12-bit converter. In the 12-bit case the code is left-justified in the 16-bit word and its four low bits are dropped.

Top module: `dac_pair_loader`

## Requirements
- R1: After reset, both outputs are zero, both holding registers read back as zero, and both range codes are 2 (`rangeOut` = 4'b1010).
- R2: Channel n (n = 0, 1) has its low byte at address `DAC_BASE`+2n and its high byte at `DAC_BASE`+2n+1. Byte writes take their data from `wrData[7:0]`.
- R3: A byte write to a low-byte address replaces holding bits 7:0 of that channel only. It never changes either output, in either mode.
- R4: With `xferMode`=0, a byte write to a high-byte address sets holding bits 15:8. At that same clock edge the channel's output takes the newly assembled holding value. The other channel's output is unchanged.
- R5: A write with `wrWord`=1 to a channel's low-byte address loads all 16 holding bits at once and commits like a high-byte write. A word write to a high-byte address is ignored.
- R6: With `xferMode`=1, writes change only the holding registers. A read of any address from `DAC_BASE` to `DAC_BASE`+3 makes both outputs take their holding values at that edge. With `xferMode`=0, reads never change the outputs.
- R7: With `DATA_W`=12, holding bits 3:0 are ignored and read back as zero, and the output is holding bits 15:4. With `DATA_W`=16, the output is the full holding value.
- R8: A write to `RANGE_ADDR` stores `wrData[5:4]` as the channel 0 code and `wrData[7:6]` as the channel 1 code. `rangeOut[1:0]` is channel 0 and `rangeOut[3:2]` is channel 1. Bits 3:0 of the register are not stored.
- R9: `rdData` is registered and valid in the cycle after `rdEn`. It returns the channel's holding word for either of its addresses, {8'h00, code1, code0, 4'h0} for `RANGE_ADDR`, and zero for any other address. It holds its value when there is no read.
- R10: When `wrEn` and `rdEn` are both high, the write is performed and the read is dropped: there is no `rdData` update and no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferMode | input | 1 | 0 = individual commit on high byte, 1 = commit both channels on read |
| wrEn | input | 1 | Bus write strobe |
| wrWord | input | 1 | Write carries a 16-bit word instead of a byte |
| rdEn | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address |
| wrData | input | 16 | Write data (byte writes use bits 7:0) |
| rdData | output | 16 | Registered read data |
| dacOut | output | 2*DATA_W | Output codes, channel 0 in the low field |
| rangeOut | output | 4 | Range codes, channel 0 in bits 1:0 |

## Verification
Several properties are checked on every cycle:
- a low-byte write leaves its output unchanged;
- every commit strobe leaves the output equal to the holding value;
- in transfer mode a write never moves an output;
- in individual mode a read never moves an output;
- a colliding read leaves `rdData` unchanged;
- the range register changes only when it is written.

Other behaviour needs the bench's scenarios: the assembled byte order, the address map, the 12-bit truncation seen at both ports, the read-back values, and that a transfer read updates both channels from their last loaded values. The bench shows these by sweeping data patterns over both channels, both modes and both widths.

// File: rtl/dacl_pkg.sv
package dacl_pkg;
  localparam int DACL_CH = 2;

  typedef struct packed {
    logic [DACL_CH-1:0] loLoad;
    logic [DACL_CH-1:0] hiLoad;
    logic [DACL_CH-1:0] wordLoad;
    logic [DACL_CH-1:0] commit;
    logic [DACL_CH-1:0] rdHold;
    logic               rdRange;
    logic               rdAcc;
    logic               rangeLoad;
  } dacStrobe_t;
endpackage

// File: rtl/dacl_ctrl.sv
module dacl_ctrl
  import dacl_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DAC_BASE   = 4,
  parameter int RANGE_ADDR = 10
) (
  input  logic              wrEn,
  input  logic              wrWord,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              xferMode,
  output dacStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] DAC_LO = ADDR_W'(DAC_BASE);
  localparam logic [ADDR_W-1:0] DAC_HI = ADDR_W'(DAC_BASE + 2*DACL_CH - 1);
  localparam logic [ADDR_W-1:0] RNG_A  = ADDR_W'(RANGE_ADDR);

  logic wrAcc, rdAcc, inDac;

  assign wrAcc = wrEn;
  assign rdAcc = rdEn && !wrEn;
  assign inDac = (addr >= DAC_LO) && (addr <= DAC_HI);

  always_comb begin
    strb = '0;
    strb.rdAcc     = rdAcc;
    strb.rangeLoad = wrAcc && (addr == RNG_A);
    strb.rdRange   = rdAcc && (addr == RNG_A);
    for (int ch = 0; ch < DACL_CH; ch++) begin
      if (wrAcc && addr == ADDR_W'(DAC_BASE + 2*ch)) begin
        if (wrWord) strb.wordLoad[ch] = 1'b1;
        else        strb.loLoad[ch]   = 1'b1;
      end
      if (wrAcc && !wrWord && addr == ADDR_W'(DAC_BASE + 2*ch + 1))
        strb.hiLoad[ch] = 1'b1;
      strb.rdHold[ch] = rdAcc && (addr == ADDR_W'(DAC_BASE + 2*ch) ||
                                  addr == ADDR_W'(DAC_BASE + 2*ch + 1));
      strb.commit[ch] = xferMode ? (rdAcc && inDac)
                                 : (strb.hiLoad[ch] || strb.wordLoad[ch]);
    end
  end
endmodule

// File: rtl/dacl_data.sv
module dacl_data
  import dacl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dacStrobe_t                strb,
  input  logic [15:0]               wrData,
  output logic [15:0]               rdData,
  output logic [DACL_CH*DATA_W-1:0] dacOut,
  output logic [2*DACL_CH-1:0]      rangeOut
);
  localparam int          IGN_W     = 16 - DATA_W;
  localparam logic [15:0] HOLD_MASK = ~16'((32'd1 << IGN_W) - 32'd1);

  logic [15:0]       hold     [DACL_CH];
  logic [15:0]       nextHold [DACL_CH];
  logic [DATA_W-1:0] outReg   [DACL_CH];
  logic [2*DACL_CH-1:0] rangeReg;
  logic [15:0]       rdNext;

  always_comb begin
    for (int ch = 0; ch < DACL_CH; ch++) begin
      nextHold[ch] = hold[ch];
      if (strb.wordLoad[ch])    nextHold[ch] = wrData;
      else if (strb.loLoad[ch]) nextHold[ch] = {hold[ch][15:8], wrData[7:0]};
      else if (strb.hiLoad[ch]) nextHold[ch] = {wrData[7:0], hold[ch][7:0]};
      nextHold[ch] = nextHold[ch] & HOLD_MASK;
    end
  end

  always_comb begin
    rdNext = '0;
    for (int ch = 0; ch < DACL_CH; ch++)
      if (strb.rdHold[ch]) rdNext = hold[ch];
    if (strb.rdRange) rdNext = {8'h00, rangeReg, 4'h0};
  end

  for (genvar ch = 0; ch < DACL_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        hold[ch]   <= '0;
        outReg[ch] <= '0;
      end else begin
        hold[ch] <= nextHold[ch];
        if (strb.commit[ch]) outReg[ch] <= nextHold[ch][15 -: DATA_W];
      end
    end
    assign dacOut[ch*DATA_W +: DATA_W] = outReg[ch];

    AST_LO_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      strb.loLoad[ch] |=> $stable(outReg[ch])); // R3
    AST_COMMIT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
      strb.commit[ch] |=> outReg[ch] == hold[ch][15 -: DATA_W]); // R4
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rangeReg <= 4'b1010;
      rdData   <= '0;
    end else begin
      if (strb.rangeLoad) rangeReg <= wrData[7:4];
      if (strb.rdAcc)     rdData   <= rdNext;
    end
  end
  assign rangeOut = rangeReg;

  AST_RANGE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rangeLoad |=> $stable(rangeReg)); // R8
endmodule

// File: rtl/dac_pair_loader.sv
module dac_pair_loader
  import dacl_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int DAC_BASE   = 4,
  parameter int RANGE_ADDR = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      xferMode,
  input  logic                      wrEn,
  input  logic                      wrWord,
  input  logic                      rdEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [15:0]               wrData,
  output logic [15:0]               rdData,
  output logic [DACL_CH*DATA_W-1:0] dacOut,
  output logic [2*DACL_CH-1:0]      rangeOut
);
  dacStrobe_t strb;

  dacl_ctrl #(
    .ADDR_W(ADDR_W), .DAC_BASE(DAC_BASE), .RANGE_ADDR(RANGE_ADDR)
  ) u_ctrl (
    .wrEn(wrEn), .wrWord(wrWord), .rdEn(rdEn), .addr(addr),
    .xferMode(xferMode), .strb(strb)
  );

  dacl_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdData(rdData), .dacOut(dacOut), .rangeOut(rangeOut)
  );

  AST_XFER_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (xferMode && wrEn) |=> $stable(dacOut)); // R6
  AST_INDIV_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!xferMode && !wrEn) |=> $stable(dacOut)); // R6
  AST_COLLIDE_RD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn) |=> $stable(rdData)); // R10
endmodule

// File: tb/sim_dac_pair_loader.sv
module sim_dac_pair_loader;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0, mode = 0, wrEn = 0, wrWord = 0, rdEn = 0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdA, rdB;
  logic [31:0] outA;
  logic [23:0] outB;
  logic [3:0]  rngA, rngB;

  int total = 0, bad = 0;
  bit done = 0;

  logic [15:0] mHold [2];
  logic [15:0] mOut  [2];
  logic [3:0]  mRng;
  logic [15:0] mRd;
  logic        mRdValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_pair_loader #(.DATA_W(16)) u0 (
    .clk(clk), .rstN(rstN), .xferMode(mode), .wrEn(wrEn), .wrWord(wrWord),
    .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdA),
    .dacOut(outA), .rangeOut(rngA));

  dac_pair_loader #(.DATA_W(12)) u1 (
    .clk(clk), .rstN(rstN), .xferMode(mode), .wrEn(wrEn), .wrWord(wrWord),
    .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdB),
    .dacOut(outB), .rangeOut(rngB));

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "u0 ch0 out", 32'(outA[15:0]),  32'(mOut[0]));
    chk(tag, "u0 ch1 out", 32'(outA[31:16]), 32'(mOut[1]));
    chk(tag, "u1 ch0 out R7", 32'(outB[11:0]),  32'(mOut[0][15:4]));
    chk(tag, "u1 ch1 out R7", 32'(outB[23:12]), 32'(mOut[1][15:4]));
    chk(tag, "range u0 R8", 32'(rngA), 32'(mRng));
    chk(tag, "range u1 R8", 32'(rngB), 32'(mRng));
    if (mRdValid) begin
      chk(tag, "u0 rdData R9", 32'(rdA), 32'(mRd));
      chk(tag, "u1 rdData R7", 32'(rdB), 32'(mRd & 16'hFFF0));
    end
  endtask

  task automatic modelOp(input logic we, input logic ww, input logic re,
                         input logic [3:0] a, input logic [15:0] d);
    if (we) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (a == 4'(4 + 2*ch)) begin
          if (ww) mHold[ch] = d;
          else    mHold[ch][7:0] = d[7:0];
          if (ww && !mode) mOut[ch] = mHold[ch];
        end
        if (a == 4'(5 + 2*ch) && !ww) begin
          mHold[ch][15:8] = d[7:0];
          if (!mode) mOut[ch] = mHold[ch];
        end
      end
      if (a == 4'd10) mRng = d[7:4];
    end else if (re) begin
      if (mode && a >= 4'd4 && a <= 4'd7) begin
        mOut[0] = mHold[0];
        mOut[1] = mHold[1];
      end
      if (a == 4'd4 || a == 4'd5)      mRd = mHold[0];
      else if (a == 4'd6 || a == 4'd7) mRd = mHold[1];
      else if (a == 4'd10)             mRd = {8'h00, mRng, 4'h0};
      else                             mRd = 16'h0;
      mRdValid = 1'b1;
    end
  endtask

  task automatic busOp(input string tag, input logic we, input logic ww,
                       input logic re, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = we; wrWord = ww; rdEn = re; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; wrWord = 0; rdEn = 0;
    modelOp(we, ww, re, a, d);
    checkAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mHold[0] = 0; mHold[1] = 0; mOut[0] = 0; mOut[1] = 0;
    mRng = 4'b1010; mRd = 0; mRdValid = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1;
    checkAll("R1 reset");
    busOp("R1 reset readback", 0, 0, 1, 4'd4, 16'h0);
    busOp("R1 reset readback", 0, 0, 1, 4'd7, 16'h0);

    // Individual mode: byte loads over both channels (R2 R3 R4)
    mode = 0;
    for (int k = 0; k < 12; k++) begin
      for (int ch = 0; ch < 2; ch++) begin
        logic [15:0] v;
        v = 16'(k * 16'h1357 + ch * 16'h0F0F + 16'h00A5);
        busOp("R3 low byte", 1, 0, 0, 4'(4 + 2*ch), {8'hEE, v[7:0]});
        busOp("R4 high byte", 1, 0, 0, 4'(5 + 2*ch), {8'h33, v[15:8]});
        busOp("R2 read low addr", 0, 0, 1, 4'(4 + 2*ch), 16'h0);
        busOp("R2 read high addr", 0, 0, 1, 4'(5 + 2*ch), 16'h0);
      end
    end

    // Word writes (R5)
    for (int k = 0; k < 8; k++) begin
      for (int ch = 0; ch < 2; ch++) begin
        busOp("R5 word load", 1, 1, 0, 4'(4 + 2*ch), 16'(k * 16'h2469 + 16'h1F0F + ch));
        busOp("R5 word odd addr ignored", 1, 1, 0, 4'(5 + 2*ch), 16'hBEEF);
        busOp("R5 readback", 0, 0, 1, 4'(4 + 2*ch), 16'h0);
      end
    end

    // Transfer mode (R6)
    mode = 1;
    for (int k = 0; k < 8; k++) begin
      busOp("R6 xfer low", 1, 0, 0, 4'd4, 16'(8'h11 * k));
      busOp("R6 xfer high", 1, 0, 0, 4'd5, 16'(8'h2D + k));
      busOp("R6 xfer word", 1, 1, 0, 4'd6, 16'(16'h9C41 ^ (k * 16'h0777)));
      busOp("R6 xfer read commits both", 0, 0, 1, 4'(4 + (k % 4)), 16'h0);
    end
    busOp("R6 xfer hi no commit", 1, 0, 0, 4'd7, 16'h00C3);
    busOp("R6 non-dac read no commit", 0, 0, 1, 4'd10, 16'h0);
    busOp("R6 dac read commits", 0, 0, 1, 4'd6, 16'h0);

    // Collision: write wins, read dropped (R10)
    busOp("R10 collide", 1, 0, 1, 4'd5, 16'h005A);
    busOp("R10 collide", 1, 1, 1, 4'd6, 16'h1234);
    busOp("R10 then read", 0, 0, 1, 4'd4, 16'h0);

    // Individual mode reads do not commit (R6)
    mode = 0;
    busOp("R3 low no commit", 1, 0, 0, 4'd6, 16'h0077);
    busOp("R6 indiv read no commit", 0, 0, 1, 4'd7, 16'h0);

    // Range register (R8)
    for (int v = 0; v < 16; v++) begin
      busOp("R8 range write", 1, 0, 0, 4'd10, 16'({v[3:0], 4'(v * 3)}));
      busOp("R8 range read", 0, 0, 1, 4'd10, 16'h0);
    end

    // Unmapped read (R9)
    busOp("R9 unmapped read", 0, 0, 1, 4'd0, 16'h0);
    busOp("R9 unmapped read", 0, 0, 1, 4'd15, 16'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule